// File: doc/BRIEF.md
# Four-times oversampling bit clock recovery

This block recovers the bit clock and the line level of a full-speed serial stream. It samples the receiver output at four times the bit rate. Two synchronized copies of the line are kept: one taken on the rising edge of the oversample clock and one on the falling edge. A 4-bit state machine first hunts for line edges. Once two edges have been seen, it enters one of two four-state loops, one for each line level. Each pass round a loop is one bit time.

When a line edge arrives one oversample early, the machine leaves its loop early, which shortens the low phase of the recovered clock by one cycle. When an edge arrives one oversample late, the machine passes through a stretch state, which adds one cycle to the high phase. This keeps the recovered clock centred on the data while the transmitter's bit rate drifts against the local clock.

The outputs are:
- a registered recovered clock;
- a one-cycle bit strobe in the oversample domain;
- the recovered line bit;
- a lock flag.

The downstream logic (NRZI decoding, unstuffing and packet framing) uses the line bit only when the strobe is high.

Top module: `dpll_rx`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, locked_o, rclk_o and strobe_o are 0.
- R2: If rx_en_i is low at a clock edge, then from the next cycle locked_o, rclk_o and strobe_o are 0. Line edges seen while disabled have no effect on them.
- R3: With the block enabled, a single line edge leaves locked_o at 0. A second edge sets locked_o to 1 within eight oversample cycles.
- R4: At the nominal rate (four oversample cycles per bit), exactly one strobe is produced per bit. bit_o during each strobe equals the transmitted line level (1 = line high), in transmit order.
- R5: Bit recovery as in R4 holds when the bit period is 0.25 % longer or 0.25 % shorter than nominal.
- R6: An edge one oversample early shortens the next low phase of rclk_o to one cycle. With bits 2 % short, low runs of one cycle appear, no high run of three cycles appears, and recovery stays error-free.
- R7: An edge one oversample late stretches the high phase of rclk_o to three cycles. With bits 2 % long, high runs of three cycles appear, no low run of one cycle appears, and recovery stays error-free.
- R8: strobe_o is high only while rclk_o is high. Two strobes are at least three cycles apart. The number of strobes equals the number of bits sent, with none lost and none added.
- R9: While locked on a steady line level, bit_o equals that level (1 for high, 0 for low).
- R10: While locked, rclk_o high runs last two or three cycles and low runs last one or two cycles. While unlocked, rclk_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversample clock, four cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable; low forces re-acquisition |
| rx_line_i | input | 1 | Differential receiver output, asynchronous |
| rclk_o | output | 1 | Registered recovered bit clock |
| bit_o | output | 1 | Recovered line level, valid with strobe_o while locked |
| strobe_o | output | 1 | One-cycle pulse per recovered bit |
| locked_o | output | 1 | Machine is tracking, not acquiring |

## Verification
The strobe state of each loop is also the state that judges an early edge. In that state, the block both emits a bit and shortens the following low phase in the same cycle. Likewise, a late edge stretches the high phase in the cycle just before the strobe of the next bit.

Streams at 2 % short and 2 % long bit periods force these coincidences every few bits. Streams at nominal and ±0.25 % periods cover slow drift. Each recovered bit is compared against a queue of transmitted bits after a framing marker. Run lengths of rclk_o are counted to show which correction occurred. A lost or duplicated bit at a correction shows up as a mismatch or a non-empty queue.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  // bit 2 of the encoding is the recovered level
  typedef enum logic [3:0] {
    PH_Z_LO2 = 4'h0,
    PH_Z_LO1 = 4'h1,
    PH_Z_HI2 = 4'h2,
    PH_Z_HI1 = 4'h3,
    PH_O_LO2 = 4'h4,
    PH_O_LO1 = 4'h5,
    PH_O_HI2 = 4'h6,
    PH_O_HI1 = 4'h7,
    PH_Z_STR = 4'hB,
    PH_HUNT  = 4'hC,
    PH_ARM   = 4'hD,
    PH_O_STR = 4'hF
  } ph_t;

  function automatic logic ph_high(input ph_t s);
    return (s == PH_Z_HI1) || (s == PH_Z_HI2) || (s == PH_O_HI1) ||
           (s == PH_O_HI2) || (s == PH_Z_STR) || (s == PH_O_STR);
  endfunction

  function automatic logic ph_locked(input ph_t s);
    return (s != PH_HUNT) && (s != PH_ARM);
  endfunction
endpackage

// File: rtl/dpll_sampler.sv
module dpll_sampler #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          IDLE_LEVEL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] rise_pipe, fall_pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_pipe <= {SYNC_STAGES{IDLE_LEVEL}};
    else         rise_pipe <= {rise_pipe[MSB-1:0], line_i};
  end

  // second copy on the opposite edge: half a cycle fresher for tracking
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_pipe <= {SYNC_STAGES{IDLE_LEVEL}};
    else         fall_pipe <= {fall_pipe[MSB-1:0], line_i};
  end

  assign rise_o = rise_pipe[MSB];
  assign fall_o = fall_pipe[MSB];
endmodule

// File: rtl/dpll_track.sv
module dpll_track
  import dpll_pkg::*;
#(
  parameter bit IDLE_LEVEL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic acq_i,
  input  logic trk_i,
  output ph_t  state_o,
  output ph_t  next_o
);
  ph_t  st_q, st_d;
  logic acq_prev_q;
  logic edge_seen;

  assign edge_seen = acq_i ^ acq_prev_q;

  always_comb begin
    st_d = PH_HUNT;
    unique case (st_q)
      PH_HUNT:  st_d = edge_seen ? PH_ARM : PH_HUNT;
      PH_ARM:   st_d = !edge_seen ? PH_ARM : (acq_i ? PH_O_LO1 : PH_Z_LO1);
      PH_O_LO1: st_d = PH_O_HI1;
      PH_O_HI1: st_d = trk_i ? PH_O_HI2 : PH_Z_STR;  // late edge
      PH_O_HI2: st_d = trk_i ? PH_O_LO2 : PH_Z_LO1;  // early edge
      PH_O_LO2: st_d = trk_i ? PH_O_LO1 : PH_Z_LO1;
      PH_Z_LO1: st_d = PH_Z_HI1;
      PH_Z_HI1: st_d = trk_i ? PH_O_STR : PH_Z_HI2;
      PH_Z_HI2: st_d = trk_i ? PH_O_LO1 : PH_Z_LO2;
      PH_Z_LO2: st_d = trk_i ? PH_O_LO1 : PH_Z_LO1;
      PH_O_STR: st_d = PH_O_HI2;
      PH_Z_STR: st_d = PH_Z_HI2;
      default:  st_d = PH_HUNT;
    endcase
    if (!en_i) st_d = PH_HUNT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= PH_HUNT;
      acq_prev_q <= IDLE_LEVEL;
    end else begin
      st_q       <= st_d;
      acq_prev_q <= acq_i;
    end
  end

  assign state_o = st_q;
  assign next_o  = st_d;
endmodule

// File: rtl/dpll_decode.sv
module dpll_decode
  import dpll_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ph_t  state_i,
  input  ph_t  next_i,
  output logic rclk_o,
  output logic bit_o,
  output logic strobe_o,
  output logic locked_o
);
  logic rclk_q;

  // registered so the clock never glitches on state decode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rclk_q <= 1'b0;
    else         rclk_q <= ph_high(next_i);
  end

  assign rclk_o   = rclk_q;
  assign bit_o    = state_i[2];
  assign locked_o = ph_locked(state_i);
  assign strobe_o = (state_i == PH_O_HI2) || (state_i == PH_Z_HI2);
endmodule

// File: rtl/dpll_rx.sv
module dpll_rx
  import dpll_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          IDLE_LEVEL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic rx_line_i,
  output logic rclk_o,
  output logic bit_o,
  output logic strobe_o,
  output logic locked_o
);
  logic rise_s, fall_s;
  ph_t  state_q, state_d;

  dpll_sampler #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(IDLE_LEVEL)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (rx_line_i),
    .rise_o (rise_s),
    .fall_o (fall_s)
  );

  dpll_track #(.IDLE_LEVEL(IDLE_LEVEL)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rx_en_i),
    .acq_i   (rise_s),
    .trk_i   (fall_s),
    .state_o (state_q),
    .next_o  (state_d)
  );

  dpll_decode u_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state_q),
    .next_i   (state_d),
    .rclk_o   (rclk_o),
    .bit_o    (bit_o),
    .strobe_o (strobe_o),
    .locked_o (locked_o)
  );
endmodule

// File: rtl/dpll_rx_chk.sv
module dpll_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_en_i,
  input logic rclk_o,
  input logic strobe_o,
  input logic locked_o
);
  logic [2:0] hi_run, lo_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= rclk_o ? ((hi_run == 3'd7) ? hi_run : hi_run + 3'd1) : 3'd0;
      lo_run <= (locked_o && !rclk_o) ? ((lo_run == 3'd7) ? lo_run : lo_run + 3'd1) : 3'd0;
    end
  end

  a_r2_disable_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !locked_o);

  a_r10_quiet_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> (!rclk_o && !strobe_o));

  a_r8_strobe_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> rclk_o);

  a_r8_strobe_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (!$past(strobe_o) && !$past(strobe_o, 2)));

  a_r10_high_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rclk_o |-> (hi_run < 3'd3));

  a_r10_low_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !rclk_o) |-> (lo_run < 3'd2));
endmodule

bind dpll_rx dpll_rx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rx_en_i  (rx_en_i),
  .rclk_o   (rclk_o),
  .strobe_o (strobe_o),
  .locked_o (locked_o)
);

// File: tb/tb_dpll_rx.sv
`timescale 1ns/1ps
module tb_dpll_rx;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_en = 1'b0;
  logic rx_line = 1'b1;
  logic rclk, bit_v, strobe, locked;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpll_rx dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .rx_en_i   (rx_en),
    .rx_line_i (rx_line),
    .rclk_o    (rclk),
    .bit_o     (bit_v),
    .strobe_o  (strobe),
    .locked_o  (locked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // scoreboard state
  bit    exp_q[$];
  bit    arm = 0, synced = 0, have_last = 0, last_rec = 0;
  string cur_req = "R4";
  int    strobe_cnt = 0;
  int    n_h3 = 0, n_l1 = 0, n_bad = 0;
  int    run = 0;
  bit    prev_clk = 0, have_prev = 0, first_run = 0;

  // monitor: sampled away from the active edge
  always @(negedge clk) begin
    if (strobe) begin
      strobe_cnt++;
      if (arm) begin
        if (!synced) begin
          if (have_last && !last_rec && !bit_v) begin
            synced = 1;
            n_h3 = 0; n_l1 = 0; n_bad = 0;
          end
          last_rec  = bit_v;
          have_last = 1;
        end else if (exp_q.size() > 0) begin
          bit e;
          e = exp_q.pop_front();
          check(bit_v == e, cur_req, bit_v, e);
        end
      end
    end
    if (!locked) begin
      have_prev = 0;
    end else if (!have_prev) begin
      prev_clk = rclk; run = 1; have_prev = 1; first_run = 1;
    end else if (rclk == prev_clk) begin
      run++;
    end else begin
      if (!first_run) begin
        if (prev_clk) begin
          if (run == 3) n_h3++; else if (run != 2) n_bad++;
        end else begin
          if (run == 1) n_l1++; else if (run != 2) n_bad++;
        end
      end
      first_run = 0; prev_clk = rclk; run = 1;
    end
  end

  task automatic send_bit(input bit v, input realtime per);
    rx_line = v;
    #(per);
  endtask

  task automatic run_packet(input realtime per, input int nbits, input string req, input int kind);
    bit pay[$];
    bit lv;
    int same;
    logic [15:0] lfsr;
    @(negedge clk) rx_en = 1'b0;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    rx_line = 1'b1;
    repeat (8) @(negedge clk);
    lfsr = 16'hACE1 ^ 16'(nbits) ^ 16'(int'(per * 100.0));
    lv = 1'b1; same = 0;
    for (int i = 0; i < nbits; i++) begin
      bit nb;
      nb = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      if (nb == lv) same++; else same = 0;
      if (same >= 5) begin nb = ~lv; same = 0; end
      lv = nb;
      pay.push_back(nb);
    end
    foreach (pay[i]) exp_q.push_back(pay[i]);
    cur_req = req;
    synced = 0; have_last = 0; arm = 1;
    #1.31;
    for (int i = 0; i < 8; i++) send_bit(i[0], per);
    send_bit(1'b0, per);
    send_bit(1'b0, per);
    foreach (pay[i]) send_bit(pay[i], per);
    for (int i = 0; i < 8; i++) send_bit(1'b1, per);
    arm = 0;
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    exp_q.delete();
    check(n_bad == 0, "R10", n_bad, 0);
    if (kind == 1) begin
      check(n_h3 > 0, "R7", n_h3, 1);
      check(n_l1 == 0, "R7", n_l1, 0);
    end else if (kind == 2) begin
      check(n_l1 > 0, "R6", n_l1, 1);
      check(n_h3 == 0, "R6", n_h3, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int sc;
    repeat (3) @(negedge clk);
    // R1
    check(!locked && !rclk && !strobe, "R1", {locked, rclk, strobe}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!locked && !rclk && !strobe, "R1", {locked, rclk, strobe}, 0);
    rx_en = 1'b1;
    repeat (20) @(negedge clk);
    // R3: one edge only
    sc = strobe_cnt;
    rx_line = 1'b0;
    repeat (40) @(negedge clk);
    check(!locked, "R3", locked, 0);
    check(strobe_cnt == sc, "R3", strobe_cnt - sc, 0);
    rx_line = 1'b1;
    repeat (8) @(negedge clk);
    check(locked, "R3", locked, 1);
    // R9: steady levels
    repeat (40) @(negedge clk);
    check(bit_v == 1'b1, "R9", bit_v, 1);
    rx_line = 1'b0;
    repeat (20) @(negedge clk);
    check(bit_v == 1'b0, "R9", bit_v, 0);
    check(locked, "R9", locked, 1);
    // R2: disable
    rx_en = 1'b0;
    @(negedge clk);
    check(!locked && !rclk, "R2", {locked, rclk}, 0);
    sc = strobe_cnt;
    for (int i = 0; i < 6; i++) begin
      rx_line = ~rx_line;
      repeat (8) @(negedge clk);
    end
    check(!locked, "R2", locked, 0);
    check(strobe_cnt == sc, "R2", strobe_cnt - sc, 0);
    // scoreboarded streams
    run_packet(20.0,  300, "R4", 0);
    run_packet(20.05, 300, "R5", 0);
    run_packet(19.95, 300, "R5", 0);
    run_packet(20.4,  200, "R7", 1);
    run_packet(19.6,  200, "R6", 2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule